// File: doc/BRIEF.md
# Priority Vectored Interrupt Controller

This controller collects a wide set of interrupt sources and presents to the CPU a single request together with the number of the source that should be serviced. The lowest `NUM_SW` source numbers belong to software requests, which are set and cleared by register writes. The remaining source numbers follow peripheral request lines. Every source carries a 4-bit priority that can be programmed. Level 0 takes a source out of arbitration. Among the pending sources, the one with the highest level is chosen, and a tie goes to the smallest source number. That winner is forwarded only when its level is strictly greater than the current-priority mask.

Software handles nesting through the same write port. An acknowledge write saves the current mask on an internal LIFO and raises the mask to the level of the source being serviced. An end-of-interrupt write restores the saved mask. A direct write to the mask lets a task raise its level for a short time, so that tasks sharing a resource cannot preempt each other (priority ceiling). A handler can also set a low-level software request so that the rest of its work runs later, at a lower level. A separate non-maskable input bypasses arbitration and the mask entirely.

The write port has no back-pressure: a write is taken in every cycle in which `reg_wr_en` is high. The request/vector pair is a plain level output. It is held until the state changes, and it is consumed by an acknowledge write rather than by a ready handshake.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset, `irq_req` is 0, `irq_vector` is 0 and `cur_prio` is 0. All priorities are 0, all software requests are clear and the save stack is empty.
- R2: The vector of a source is its source number, zero-extended to 9 bits. Sources 0..7 are the software requests. Source k (k >= 8) is driven by `irq_lines[k-8]`.
- R3: `irq_req` is 1 exactly when the best pending level is strictly greater than `cur_prio`. The output is registered, so a change in the pending state, a priority or the mask shows up one clock edge after that state changes. While `irq_req` is 0, `irq_vector` keeps its last value.
- R4: The pending source with the highest level wins. When levels are equal, the lower source number wins.
- R5: A source whose priority is 0 is never selected, even while it is pending.
- R6: A write of data d to address 128 sets software request d[2:0]. A write to address 129 clears it. A software request stays pending through acknowledge and end-of-interrupt until it is cleared.
- R7: Peripheral requests are level-sensitive. A source is pending exactly while its line is high.
- R8: A write of data d to address 130 loads `cur_prio` with d[3:0].
- R9: A write to address 131 (acknowledge) has effect only while `irq_req` is 1 and fewer than 16 levels are saved. It pushes `cur_prio` and loads `cur_prio` with the priority of the source in `irq_vector`. In all other cases it is ignored.
- R10: A write to address 132 (end of interrupt) pops the last saved level into `cur_prio`. When the stack is empty, the write is ignored.
- R11: `crit_irq` equals `nmi_in` in the same cycle, whatever the mask and the arbitration.
- R12: A write of data d to an address a in 0..127 sets the priority of source a to d[3:0]. Addresses above 132 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | 8 | Write address |
| reg_wdata | input | 8 | Write data |
| irq_lines | input | 120 | Peripheral level requests, bit i feeds source i+8 |
| nmi_in | input | 1 | Non-maskable request |
| irq_req | output | 1 | Registered interrupt request to the CPU |
| irq_vector | output | 9 | Registered vector of the winning source |
| cur_prio | output | 4 | Current priority mask |
| crit_irq | output | 1 | Critical interrupt to the CPU |

## Verification
The bench targets five corner cases. First, a source whose level equals the mask. A comparison written as "not below" instead of "strictly above" would raise a request that ought to stay quiet. Second, equal levels at different source numbers: an arbiter that is biased the wrong way would return the higher number. Third, a level-0 source that is pending: a design that skips the zero filter would vector to a disabled source. Fourth, the save stack is driven past 16 entries and past empty. A stack without guards would overwrite an entry or wrap its pointer and then restore a wrong mask. Last, an acknowledge with no request and repeated acknowledge/end-of-interrupt on a software request are used to expose a design that clears or disturbs state when it should not.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_PRIO,
    OP_SWSET,
    OP_SWCLR,
    OP_MASK,
    OP_ACK,
    OP_EOI
  } intc_op_e;
endpackage

// File: rtl/intc_src_bank.sv
module intc_src_bank #(
  parameter int NUM_SRC = 128,
  parameter int NUM_SW  = 8,
  parameter int PRIO_W  = 4,
  parameter int IDX_W   = 7,
  parameter int SW_W    = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           prio_we,
  input  logic [IDX_W-1:0]               prio_idx,
  input  logic [PRIO_W-1:0]              prio_val,
  input  logic                           sw_set,
  input  logic                           sw_clr,
  input  logic [SW_W-1:0]                sw_idx,
  input  logic [NUM_SRC-NUM_SW-1:0]      irq_lines,
  output logic [NUM_SRC-1:0][PRIO_W-1:0] prio_tab,
  output logic [NUM_SRC-1:0][PRIO_W-1:0] eff_prio
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic [PRIO_W-1:0] lvl_q;
    logic              pend;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  lvl_q <= '0;
      else if (prio_we && prio_idx == IDX_W'(i))   lvl_q <= prio_val;
    end

    if (i < NUM_SW) begin : g_sw
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                flag_q <= 1'b0;
        else if (sw_set && sw_idx == SW_W'(i))     flag_q <= 1'b1;
        else if (sw_clr && sw_idx == SW_W'(i))     flag_q <= 1'b0;
      end
      assign pend = flag_q;
    end else begin : g_hw
      assign pend = irq_lines[i-NUM_SW];
    end

    assign prio_tab[i] = lvl_q;
    assign eff_prio[i] = pend ? lvl_q : '0;
  end
endmodule

// File: rtl/intc_arb.sv
module intc_arb #(
  parameter int NUM_SRC = 128,
  parameter int PRIO_W  = 4,
  parameter int IDX_W   = 7
) (
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] eff,
  output logic                           win_valid,
  output logic [PRIO_W-1:0]              win_prio,
  output logic [IDX_W-1:0]               win_idx
);
  localparam int LVLS = IDX_W;
  localparam int NPAD = 1 << LVLS;

  for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
    localparam int W = NPAD >> l;
    logic [PRIO_W-1:0] p [W];
    logic [IDX_W-1:0]  x [W];
    for (genvar j = 0; j < W; j++) begin : g_node
      if (l == 0) begin : g_leaf
        if (j < NUM_SRC) begin : g_real
          assign p[j] = eff[j];
        end else begin : g_pad
          assign p[j] = '0;
        end
        assign x[j] = IDX_W'(j);
      end else begin : g_cmp
        logic [PRIO_W-1:0] lp, rp;
        logic              take_r;
        assign lp     = g_lvl[l-1].p[2*j];
        assign rp     = g_lvl[l-1].p[2*j+1];
        assign take_r = rp > lp;
        assign p[j]   = take_r ? rp : lp;
        assign x[j]   = take_r ? g_lvl[l-1].x[2*j+1] : g_lvl[l-1].x[2*j];
      end
    end
  end

  assign win_prio  = g_lvl[LVLS].p[0];
  assign win_idx   = g_lvl[LVLS].x[0];
  assign win_valid = win_prio != '0;
endmodule

// File: rtl/intc_prio_stack.sv
module intc_prio_stack #(
  parameter int PRIO_W  = 4,
  parameter int DEPTH   = 16,
  parameter int DEPTH_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [PRIO_W-1:0]  push_val,
  input  logic               pop,
  input  logic               load,
  input  logic [PRIO_W-1:0]  load_val,
  output logic [PRIO_W-1:0]  cur,
  output logic [DEPTH_W-1:0] depth,
  output logic               full,
  output logic               empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PRIO_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;

  assign full   = depth == DEPTH_W'(DEPTH);
  assign empty  = depth == '0;
  assign wr_ptr = depth[PTR_W-1:0];
  assign rd_ptr = PTR_W'(depth - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur   <= '0;
      depth <= '0;
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else if (push && !full) begin
      mem[wr_ptr] <= cur;
      cur         <= push_val;
      depth       <= depth + 1'b1;
    end else if (pop && !empty) begin
      cur   <= mem[rd_ptr];
      depth <= depth - 1'b1;
    end else if (load) begin
      cur <= load_val;
    end
  end
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc #(
  parameter int NUM_SRC     = 128,
  parameter int NUM_SW      = 8,
  parameter int PRIO_W      = 4,
  parameter int VEC_W       = 9,
  parameter int STACK_DEPTH = 16,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_wr_en,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic [DATA_W-1:0]         reg_wdata,
  input  logic [NUM_SRC-NUM_SW-1:0] irq_lines,
  input  logic                      nmi_in,
  output logic                      irq_req,
  output logic [VEC_W-1:0]          irq_vector,
  output logic [PRIO_W-1:0]         cur_prio,
  output logic                      crit_irq
);
  import intc_pkg::*;

  localparam int IDX_W   = $clog2(NUM_SRC);
  localparam int SW_W    = $clog2(NUM_SW);
  localparam int DEPTH_W = $clog2(STACK_DEPTH + 1);
  localparam logic [ADDR_W-1:0] A_SWSET = ADDR_W'(NUM_SRC);
  localparam logic [ADDR_W-1:0] A_SWCLR = ADDR_W'(NUM_SRC + 1);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(NUM_SRC + 2);
  localparam logic [ADDR_W-1:0] A_ACK   = ADDR_W'(NUM_SRC + 3);
  localparam logic [ADDR_W-1:0] A_EOI   = ADDR_W'(NUM_SRC + 4);

  intc_op_e                      op;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_tab, eff_prio;
  logic                          arb_valid;
  logic [PRIO_W-1:0]             arb_prio;
  logic [IDX_W-1:0]              arb_idx;
  logic                          irq_q;
  logic [VEC_W-1:0]              vec_q;
  logic [PRIO_W-1:0]             cur_q, ack_prio;
  logic [DEPTH_W-1:0]            stk_depth;
  logic                          stk_full, stk_empty, ack_ok;

  always_comb begin
    op = OP_NONE;
    if (reg_wr_en) begin
      if (reg_addr < A_SWSET) op = OP_PRIO;
      else begin
        case (reg_addr)
          A_SWSET: op = OP_SWSET;
          A_SWCLR: op = OP_SWCLR;
          A_MASK:  op = OP_MASK;
          A_ACK:   op = OP_ACK;
          A_EOI:   op = OP_EOI;
          default: op = OP_NONE;
        endcase
      end
    end
  end

  intc_src_bank #(
    .NUM_SRC(NUM_SRC), .NUM_SW(NUM_SW), .PRIO_W(PRIO_W),
    .IDX_W(IDX_W), .SW_W(SW_W)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .prio_we   (op == OP_PRIO),
    .prio_idx  (reg_addr[IDX_W-1:0]),
    .prio_val  (reg_wdata[PRIO_W-1:0]),
    .sw_set    (op == OP_SWSET),
    .sw_clr    (op == OP_SWCLR),
    .sw_idx    (reg_wdata[SW_W-1:0]),
    .irq_lines (irq_lines),
    .prio_tab  (prio_tab),
    .eff_prio  (eff_prio)
  );

  intc_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb (
    .eff       (eff_prio),
    .win_valid (arb_valid),
    .win_prio  (arb_prio),
    .win_idx   (arb_idx)
  );

  assign ack_prio = prio_tab[vec_q[IDX_W-1:0]];
  assign ack_ok   = (op == OP_ACK) && irq_q && !stk_full;

  intc_prio_stack #(.PRIO_W(PRIO_W), .DEPTH(STACK_DEPTH), .DEPTH_W(DEPTH_W)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (ack_ok),
    .push_val (ack_prio),
    .pop      (op == OP_EOI),
    .load     (op == OP_MASK),
    .load_val (reg_wdata[PRIO_W-1:0]),
    .cur      (cur_q),
    .depth    (stk_depth),
    .full     (stk_full),
    .empty    (stk_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      vec_q <= '0;
    end else begin
      irq_q <= arb_valid && (arb_prio > cur_q);
      if (arb_valid && (arb_prio > cur_q)) vec_q <= VEC_W'(arb_idx);
    end
  end

  assign irq_req    = irq_q;
  assign irq_vector = vec_q;
  assign cur_prio   = cur_q;
  assign crit_irq   = nmi_in;

  logic unused_bits;
  assign unused_bits = ^{reg_wdata[DATA_W-1:PRIO_W], vec_q[VEC_W-1:IDX_W], stk_empty, stk_depth};
endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter int PRIO_W      = 4,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int NUM_SRC     = 128,
  parameter int STACK_DEPTH = 16,
  parameter int DEPTH_W     = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [DATA_W-1:0]  wr_data,
  input logic               irq_req,
  input logic [PRIO_W-1:0]  cur_prio,
  input logic               arb_valid,
  input logic [PRIO_W-1:0]  arb_prio,
  input logic [DEPTH_W-1:0] depth
);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(NUM_SRC + 2);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(NUM_SRC + 3);
  localparam logic [ADDR_W-1:0] A_EOI  = ADDR_W'(NUM_SRC + 4);

  a_r3_strict_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> $past(arb_prio) > $past(cur_prio));

  a_r5_no_disabled_win: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ($past(arb_valid) && $past(arb_prio) != '0));

  a_r8_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_MASK) |=> cur_prio == $past(wr_data[PRIO_W-1:0]));

  a_r9_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_ACK && irq_req && depth < DEPTH_W'(STACK_DEPTH))
      |=> depth == DEPTH_W'($past(depth) + 1'b1));

  a_r9_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= DEPTH_W'(STACK_DEPTH));

  a_r10_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_EOI && depth != '0) |=> depth == DEPTH_W'($past(depth) - 1'b1));

  a_r10_empty_eoi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_EOI && depth == '0) |=> ($stable(cur_prio) && depth == '0));
endmodule

bind prio_vec_intc intc_checker #(
  .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .NUM_SRC(NUM_SRC), .STACK_DEPTH(STACK_DEPTH), .DEPTH_W($clog2(STACK_DEPTH + 1))
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (reg_wr_en),
  .wr_addr   (reg_addr),
  .wr_data   (reg_wdata),
  .irq_req   (irq_req),
  .cur_prio  (cur_prio),
  .arb_valid (arb_valid),
  .arb_prio  (arb_prio),
  .depth     (stk_depth)
);

// File: tb/prio_vec_intc_test.sv
module prio_vec_intc_test;
  localparam int PERIOD = 10;
  localparam int NSRC = 128;
  localparam int NSW  = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr_en = 1'b0;
  logic [7:0]   reg_addr = '0;
  logic [7:0]   reg_wdata = '0;
  logic [119:0] irq_lines = '0;
  logic         nmi_in = 1'b0;
  logic         irq_req;
  logic [8:0]   irq_vector;
  logic [3:0]   cur_prio;
  logic         crit_irq;

  int n_chk = 0;
  int n_fail = 0;

  prio_vec_intc uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .irq_lines(irq_lines), .nmi_in(nmi_in),
    .irq_req(irq_req), .irq_vector(irq_vector), .cur_prio(cur_prio), .crit_irq(crit_irq)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int   m_prio [NSRC];
  bit   m_sw [NSW];
  int   m_cur;
  int   m_stk [$];
  bit   m_irq;
  int   m_vec;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_prio[i]) m_prio[i] = 0;
      foreach (m_sw[i]) m_sw[i] = 0;
      m_cur = 0; m_stk.delete(); m_irq = 0; m_vec = 0;
    end else begin
      int bp, bi, p, a, d;
      bit n_irq;
      int n_vec;
      bp = 0; bi = 0;
      for (int i = 0; i < NSRC; i++) begin
        bit pend;
        pend = (i < NSW) ? m_sw[i] : irq_lines[i-NSW];
        p = pend ? m_prio[i] : 0;
        if (p > bp) begin bp = p; bi = i; end
      end
      n_irq = (bp > m_cur);
      n_vec = n_irq ? bi : m_vec;
      if (reg_wr_en) begin
        a = reg_addr; d = reg_wdata;
        if (a < NSRC) m_prio[a] = d % 16;
        else if (a == 128) m_sw[d % 8] = 1;
        else if (a == 129) m_sw[d % 8] = 0;
        else if (a == 130) m_cur = d % 16;
        else if (a == 131) begin
          if (m_irq && m_stk.size() < 16) begin
            m_stk.push_back(m_cur);
            m_cur = m_prio[m_vec];
          end
        end else if (a == 132) begin
          if (m_stk.size() > 0) m_cur = m_stk.pop_back();
        end
      end
      m_irq = n_irq; m_vec = n_vec;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(irq_req == m_irq, "R3 R4 R5 model irq_req", irq_req, m_irq);
      chk(irq_vector == 9'(m_vec), "R2 R4 model irq_vector", irq_vector, m_vec);
      chk(cur_prio == 4'(m_cur), "R9 R10 model cur_prio", cur_prio, m_cur);
      chk(crit_irq == nmi_in, "R11 model crit_irq", crit_irq, nmi_in);
    end
  end

  task automatic wr(input int a, input int d);
    @(posedge clk); #2;
    reg_wr_en = 1'b1; reg_addr = 8'(a); reg_wdata = 8'(d);
    @(posedge clk); #2;
    reg_wr_en = 1'b0;
  endtask

  task automatic settle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic expect_out(input bit e_irq, input int e_vec, input string tag);
    chk(irq_req == e_irq, tag, irq_req, e_irq);
    if (e_irq) chk(irq_vector == 9'(e_vec), tag, irq_vector, e_vec);
  endtask

  initial begin
    #(PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(irq_req == 0, "R1 irq_req", irq_req, 0);
    chk(irq_vector == 0, "R1 irq_vector", irq_vector, 0);
    chk(cur_prio == 0, "R1 cur_prio", cur_prio, 0);

    // R7 R12 R2: peripheral line 12 is source 20
    @(posedge clk); #2 irq_lines[12] = 1'b1;
    wr(20, 5); settle();
    expect_out(1, 20, "R7 R12 R2 peripheral vector");
    // R4 tie: source 30 also level 5
    @(posedge clk); #2 irq_lines[22] = 1'b1;
    wr(30, 5); settle();
    expect_out(1, 20, "R4 tie lowest index");
    // R4 higher level wins
    @(posedge clk); #2 irq_lines[32] = 1'b1;
    wr(40, 9); settle();
    expect_out(1, 40, "R4 higher level");
    // R3 R8 mask equal blocks
    wr(130, 9); settle();
    chk(cur_prio == 9, "R8 mask load", cur_prio, 9);
    expect_out(0, 0, "R3 equal to mask blocked");
    wr(130, 8); settle();
    expect_out(1, 40, "R3 above mask passes");
    // R5 level 0 disables
    wr(40, 0); wr(130, 0); settle();
    expect_out(1, 20, "R5 disabled source skipped");
    // R6 software request
    wr(3, 12); wr(128, 3); settle();
    expect_out(1, 3, "R6 software set");
    wr(131, 0); settle();
    chk(cur_prio == 12, "R9 ack raises mask", cur_prio, 12);
    expect_out(0, 0, "R9 R3 masked after ack");
    wr(132, 0); settle();
    chk(cur_prio == 0, "R10 eoi restores", cur_prio, 0);
    expect_out(1, 3, "R6 stays pending after ack");
    wr(129, 3); settle();
    expect_out(1, 20, "R6 software clear");
    // nesting
    wr(131, 0); settle();
    chk(cur_prio == 5, "R9 ack level 5", cur_prio, 5);
    wr(5, 7); wr(128, 5); settle();
    expect_out(1, 5, "R6 nested software request");
    wr(131, 0); settle();
    chk(cur_prio == 7, "R9 nested ack", cur_prio, 7);
    wr(132, 0); settle();
    chk(cur_prio == 5, "R10 nested pop", cur_prio, 5);
    wr(132, 0); settle();
    chk(cur_prio == 0, "R10 outer pop", cur_prio, 0);
    wr(132, 0); settle();
    chk(cur_prio == 0, "R10 empty eoi ignored", cur_prio, 0);
    // R9 ack without request
    wr(129, 5);
    @(posedge clk); #2 irq_lines = '0;
    settle();
    expect_out(0, 0, "R7 lines dropped");
    wr(131, 0); settle();
    chk(cur_prio == 0, "R9 ack without request ignored", cur_prio, 0);
    // R9 stack full
    @(posedge clk); #2 irq_lines[12] = 1'b1;
    for (int k = 0; k < 16; k++) begin
      settle(); wr(131, 0); wr(130, 0);
    end
    settle();
    expect_out(1, 20, "R9 request before full ack");
    wr(131, 0); settle();
    chk(cur_prio == 0, "R9 ack on full stack ignored", cur_prio, 0);
    for (int k = 0; k < 16; k++) wr(132, 0);
    // R11 NMI bypasses mask
    wr(130, 15);
    @(posedge clk); #2 nmi_in = 1'b1;
    @(negedge clk);
    chk(crit_irq == 1, "R11 nmi passes mask", crit_irq, 1);
    @(posedge clk); #2 nmi_in = 1'b0;
    @(negedge clk);
    chk(crit_irq == 0, "R11 nmi follows", crit_irq, 0);
    // R12 out-of-range address ignored
    wr(200, 15); wr(130, 0); settle();
    expect_out(1, 20, "R12 high address no effect");
    // random traffic against model
    for (int c = 0; c < 4000; c++) begin
      @(posedge clk); #2;
      reg_wr_en = ($urandom_range(0, 9) < 4);
      reg_addr  = 8'($urandom_range(0, 140));
      reg_wdata = 8'($urandom);
      if ($urandom_range(0, 3) == 0) irq_lines[$urandom_range(0, 119)] ^= 1'b1;
      if ($urandom_range(0, 15) == 0) nmi_in = ~nmi_in;
    end
    @(posedge clk); #2 reg_wr_en = 1'b0;
    settle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule